// File: doc/BRIEF.md
# Sliding DFT Bin Engine

This block keeps the lower half of the N-point discrete Fourier spectrum of a real sample stream current at all times. It does not recompute a block transform. Each new sample from the converter updates every bin by a recursive step. First the difference between the newest sample and the sample that is leaving the N-sample window is added to the bin's real part. Then the bin is rotated by that bin's fixed-point twiddle factor. After every sample, the bins hold the transform of the last N samples.

One shared multiplier does all four partial products of each complex rotation, one bin at a time. The twiddle factors are quantized to the full signed coefficient range. Each rotated result is divided by that full-scale value so the bins keep their magnitude. A sample that arrives while the bins are still updating waits in a one-entry holding register. A strobe that would displace that held sample is dropped and recorded in a sticky flag. A one-cycle completion pulse tells the consumer that all bins are current. The consumer then reads them through an indexed combinational port.

Top module: `sdft_engine`

## Requirements
- R1: While reset is asserted and after it is released, every bin reads 0 on both real and imaginary outputs, and `done_o` and `overrun_o` are 0.
- R2: For each accepted sample, bin k (0 <= k < N/2) is updated as a = re + d, b = im, re' = (a*c - b*s)/A, im' = (a*s + b*c)/A. Here c and s are round(A*cos(2*pi*k/N)) and round(A*sin(2*pi*k/N)), with halves rounded away from zero, and A = 2^(TW-1)-1 (127 for TW=8). The division truncates toward zero, and the result is wrapped to BW-bit two's complement.
- R3: The comb term d is the new sample minus the sample accepted N samples earlier, with 0 used before N samples have been accepted. The new sample replaces that oldest entry.
- R4: `smp_valid_i` and `smp_data_i` are sampled on the falling clock edge. A strobe that is high only around a falling edge is accepted.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last bin of a sample has been written. All bins already hold the new results in that cycle.
- R6: A strobe that arrives while the bins are being updated is held and is processed after the current update, in arrival order.
- R7: A strobe that arrives while a held sample is still waiting is discarded and sets `overrun_o`. `overrun_o` stays high until reset.
- R8: `rd_bin_i` = k selects bin k. Its real part appears on `rd_re_o` and its imaginary part on `rd_im_o`, combinationally.
- R9: Asserting reset in the middle of a stream clears the sample window and its write position as well as the bins. The next sample is then processed as the first of a new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; converter inputs are sampled on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | New-sample strobe |
| smp_data_i | input | W | Signed input sample |
| rd_bin_i | input | log2(N/2) | Bin index for the read port |
| rd_re_o | output | BW | Real part of the selected bin |
| rd_im_o | output | BW | Imaginary part of the selected bin |
| done_o | output | 1 | One-cycle pulse: all bins updated |
| overrun_o | output | 1 | Sticky flag: a sample was dropped |

## Verification
The checker watches the control behaviour on every cycle. It checks that the completion pulse is one cycle wide and comes only after the write of the last bin. It also checks that the overrun flag is sticky, that the window pointer advances by exactly one per accepted sample, and that the sequencer returns to idle after finishing. The bin values themselves can only be shown by the bench scenarios. The bench compares each bin against an independent model of the rotation recursion across an impulse, full-scale extremes, a stream longer than the window, a burst that overruns the holding register, and a reset in mid-stream.

// File: rtl/sdft_pkg.sv
package sdft_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_WB, ST_FIN} sdft_state_e;

  localparam real SDFT_PI = 3.14159265358979323846;

  // cos(t) = -cos(t - pi); the series is evaluated on [-pi, pi)
  function automatic real sdft_cos(input int k, input int n);
    real x, term, sum;
    x    = 2.0 * SDFT_PI * real'(k) / real'(n) - SDFT_PI;
    term = 1.0;
    sum  = 1.0;
    for (int i = 1; i <= 20; i++) begin
      term = -term * x * x / (real'(2 * i - 1) * real'(2 * i));
      sum  = sum + term;
    end
    return -sum;
  endfunction

  function automatic real sdft_sin(input int k, input int n);
    real x, term, sum;
    x    = 2.0 * SDFT_PI * real'(k) / real'(n) - SDFT_PI;
    term = x;
    sum  = x;
    for (int i = 1; i <= 20; i++) begin
      term = -term * x * x / (real'(2 * i) * real'(2 * i + 1));
      sum  = sum + term;
    end
    return -sum;
  endfunction

  function automatic int sdft_quant(input real v, input int amp);
    real s;
    s = v * real'(amp);
    return (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
  endfunction

endpackage

// File: rtl/sdft_twiddle_rom.sv
module sdft_twiddle_rom
  import sdft_pkg::*;
#(
  parameter int N   = 16,
  parameter int K   = 8,
  parameter int KW  = 3,
  parameter int TW  = 8,
  parameter int AMP = 127
) (
  input  logic [KW-1:0]        bin_i,
  output logic signed [TW-1:0] cos_o,
  output logic signed [TW-1:0] sin_o
);

  logic signed [TW-1:0] cos_tab [K];
  logic signed [TW-1:0] sin_tab [K];

  for (genvar g = 0; g < K; g++) begin : g_tab
    assign cos_tab[g] = TW'(sdft_quant(sdft_cos(g, N), AMP));
    assign sin_tab[g] = TW'(sdft_quant(sdft_sin(g, N), AMP));
  end

  assign cos_o = cos_tab[bin_i];
  assign sin_o = sin_tab[bin_i];

endmodule

// File: rtl/sdft_sample_window.sv
module sdft_sample_window #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int PW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic signed [W-1:0] data_i,
  output logic signed [W:0]   delta_o,
  output logic [PW-1:0]       ptr_o
);

  logic signed [W-1:0] mem_q [N];
  logic [PW-1:0]       ptr_q;
  logic signed [W-1:0] oldest;

  assign oldest  = mem_q[ptr_q];
  assign delta_o = (W+1)'(data_i) - (W+1)'(oldest);
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= data_i;
      ptr_q        <= ptr_q + PW'(1);
    end
  end

endmodule

// File: rtl/sdft_bin_core.sv
module sdft_bin_core #(
  parameter int K   = 8,
  parameter int KW  = 3,
  parameter int W   = 8,
  parameter int TW  = 8,
  parameter int BW  = 24,
  parameter int AMP = 127
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [W:0]    delta_i,
  input  logic [KW-1:0]        bin_i,
  input  logic [1:0]           step_i,
  input  logic                 mul_i,
  input  logic                 wb_i,
  input  logic signed [TW-1:0] cos_i,
  input  logic signed [TW-1:0] sin_i,
  input  logic [KW-1:0]        rd_bin_i,
  output logic signed [BW-1:0] rd_re_o,
  output logic signed [BW-1:0] rd_im_o
);

  localparam int OW = BW + 1;
  localparam int PWD = OW + TW;
  localparam int AW = BW + TW + 2;
  localparam logic signed [AW-1:0] DIV = AW'(AMP);

  logic signed [BW-1:0]  re_q [K];
  logic signed [BW-1:0]  im_q [K];
  logic signed [W:0]     delta_q;
  logic signed [OW-1:0]  sum_re, op_a;
  logic signed [TW-1:0]  op_b;
  logic signed [PWD-1:0] prod;
  logic signed [AW-1:0]  prod_x, acc_re_q, acc_im_q, q_re, q_im;

  assign sum_re = OW'(re_q[bin_i]) + OW'(delta_q);
  // steps: 0 a*c, 1 b*s, 2 a*s, 3 b*c
  assign op_a   = step_i[0] ? OW'(im_q[bin_i]) : sum_re;
  assign op_b   = (step_i == 2'd1 || step_i == 2'd2) ? sin_i : cos_i;
  assign prod   = op_a * op_b;
  assign prod_x = AW'(prod);
  assign q_re   = acc_re_q / DIV;
  assign q_im   = acc_im_q / DIV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delta_q  <= '0;
      acc_re_q <= '0;
      acc_im_q <= '0;
      for (int i = 0; i < K; i++) begin
        re_q[i] <= '0;
        im_q[i] <= '0;
      end
    end else begin
      if (start_i) delta_q <= delta_i;
      if (mul_i) begin
        case (step_i)
          2'd0:    acc_re_q <= prod_x;
          2'd1:    acc_re_q <= acc_re_q - prod_x;
          2'd2:    acc_im_q <= prod_x;
          default: acc_im_q <= acc_im_q + prod_x;
        endcase
      end
      if (wb_i) begin
        re_q[bin_i] <= q_re[BW-1:0];
        im_q[bin_i] <= q_im[BW-1:0];
      end
    end
  end

  assign rd_re_o = re_q[rd_bin_i];
  assign rd_im_o = im_q[rd_bin_i];

endmodule

// File: rtl/sdft_engine.sv
module sdft_engine
  import sdft_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int TW = 8,
  parameter int BW = 24,
  localparam int K   = N / 2,
  localparam int KW  = $clog2(K),
  localparam int PW  = $clog2(N),
  localparam int AMP = 2 ** (TW - 1) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic signed [W-1:0]  smp_data_i,
  input  logic [KW-1:0]        rd_bin_i,
  output logic signed [BW-1:0] rd_re_o,
  output logic signed [BW-1:0] rd_im_o,
  output logic                 done_o,
  output logic                 overrun_o
);

  if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_n
    $error("sdft_engine: N must be a power of two, at least 4");
  end

  logic                adc_vld_q;
  logic signed [W-1:0] adc_dat_q;
  logic                pend_q;
  logic signed [W-1:0] pend_dat_q;
  logic                ovr_q;
  sdft_state_e         state_q;
  logic [KW-1:0]       bin_q;
  logic [1:0]          step_q;
  logic                take;
  logic signed [W:0]   delta;
  logic [PW-1:0]       win_ptr;
  logic signed [TW-1:0] tw_cos, tw_sin;

  // converter side is sampled on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_vld_q <= 1'b0;
      adc_dat_q <= '0;
    end else begin
      adc_vld_q <= smp_valid_i;
      adc_dat_q <= smp_data_i;
    end
  end

  assign take = (state_q == ST_IDLE) && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_dat_q <= '0;
      ovr_q      <= 1'b0;
    end else if (adc_vld_q) begin
      if (pend_q && !take) begin
        ovr_q <= 1'b1;
      end else begin
        pend_q     <= 1'b1;
        pend_dat_q <= adc_dat_q;
      end
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bin_q   <= '0;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_MUL;
          bin_q   <= '0;
          step_q  <= '0;
        end
        ST_MUL: begin
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) state_q <= ST_WB;
        end
        ST_WB: begin
          if (bin_q == KW'(K - 1)) begin
            state_q <= ST_FIN;
          end else begin
            bin_q   <= bin_q + KW'(1);
            state_q <= ST_MUL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sdft_sample_window #(.N(N), .W(W), .PW(PW)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (take),
    .data_i  (pend_dat_q),
    .delta_o (delta),
    .ptr_o   (win_ptr)
  );

  sdft_twiddle_rom #(.N(N), .K(K), .KW(KW), .TW(TW), .AMP(AMP)) u_rom (
    .bin_i (bin_q),
    .cos_o (tw_cos),
    .sin_o (tw_sin)
  );

  sdft_bin_core #(.K(K), .KW(KW), .W(W), .TW(TW), .BW(BW), .AMP(AMP)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (take),
    .delta_i  (delta),
    .bin_i    (bin_q),
    .step_i   (step_q),
    .mul_i    (state_q == ST_MUL),
    .wb_i     (state_q == ST_WB),
    .cos_i    (tw_cos),
    .sin_i    (tw_sin),
    .rd_bin_i (rd_bin_i),
    .rd_re_o  (rd_re_o),
    .rd_im_o  (rd_im_o)
  );

  assign done_o    = (state_q == ST_FIN);
  assign overrun_o = ovr_q;

endmodule

// File: rtl/sdft_engine_chk.sv
module sdft_engine_chk
  import sdft_pkg::*;
#(
  parameter int K  = 8,
  parameter int KW = 3,
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_i,
  input logic          overrun_i,
  input sdft_state_e   state_i,
  input logic [KW-1:0] bin_i,
  input logic          take_i,
  input logic [PW-1:0] ptr_i
);

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R5
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(state_i == ST_WB && bin_i == KW'(K - 1)));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> overrun_i);

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> ptr_i == $past(ptr_i) + PW'(1));

  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(ptr_i));

  // R6
  fin_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FIN |=> state_i == ST_IDLE);

endmodule

bind sdft_engine sdft_engine_chk #(.K(K), .KW(KW), .PW(PW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_i    (done_o),
  .overrun_i (overrun_o),
  .state_i   (state_q),
  .bin_i     (bin_q),
  .take_i    (take),
  .ptr_i     (win_ptr)
);

// File: tb/sdft_engine_bench.sv
`timescale 1ns/1ps
module sdft_engine_bench;

  localparam int N   = 16;
  localparam int W   = 8;
  localparam int TW  = 8;
  localparam int BW  = 24;
  localparam int K   = N / 2;
  localparam int KW  = $clog2(K);
  localparam int AMP = 2 ** (TW - 1) - 1;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 smp_valid_i = 1'b0;
  logic signed [W-1:0]  smp_data_i = '0;
  logic [KW-1:0]        rd_bin_i = '0;
  logic signed [BW-1:0] rd_re_o, rd_im_o;
  logic                 done_o, overrun_o;

  int errors = 0;
  int checks = 0;

  longint m_re [K];
  longint m_im [K];
  longint tc [K];
  longint ts [K];
  int     hist [N];
  int     hptr;

  always #2.5 clk = ~clk;

  sdft_engine #(.N(N), .W(W), .TW(TW), .BW(BW)) u_sdft_engine (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .rd_bin_i    (rd_bin_i),
    .rd_re_o     (rd_re_o),
    .rd_im_o     (rd_im_o),
    .done_o      (done_o),
    .overrun_o   (overrun_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wrap_bw(input longint v);
    longint m;
    m = v & ((longint'(1) <<< BW) - 1);
    if (m >= (longint'(1) <<< (BW - 1))) m = m - (longint'(1) <<< BW);
    return m;
  endfunction

  function automatic longint qround(input real v);
    real s;
    s = v * real'(AMP);
    return (s >= 0.0) ? longint'($rtoi(s + 0.5)) : longint'($rtoi(s - 0.5));
  endfunction

  task automatic model_clear();
    for (int k = 0; k < K; k++) begin
      m_re[k] = 0;
      m_im[k] = 0;
    end
    for (int i = 0; i < N; i++) hist[i] = 0;
    hptr = 0;
  endtask

  task automatic model_push(input int v);
    longint d, a, b;
    d = longint'(v - hist[hptr]);
    hist[hptr] = v;
    hptr = (hptr + 1) % N;
    for (int k = 0; k < K; k++) begin
      a = m_re[k] + d;
      b = m_im[k];
      m_re[k] = wrap_bw((a * tc[k] - b * ts[k]) / AMP);
      m_im[k] = wrap_bw((a * ts[k] + b * tc[k]) / AMP);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    model_clear();
  endtask

  // strobe is high only across the falling edge (R4)
  task automatic send_sample(input int v);
    @(posedge clk); #1;
    smp_data_i  = W'(v);
    smp_valid_i = 1'b1;
    #2;
    smp_valid_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done_o && n < 400) begin
      @(posedge clk); #1;
      n++;
    end
    chk({tag, " R5 done seen"}, longint'(done_o), 1);
    @(posedge clk); #1;
    chk({tag, " R5 done one cycle"}, longint'(done_o), 0);
  endtask

  task automatic check_bins(input string tag);
    for (int k = 0; k < K; k++) begin
      rd_bin_i = KW'(k);
      #0.5;
      chk($sformatf("%s R2 R8 bin%0d re", tag, k), longint'(rd_re_o), m_re[k]);
      chk($sformatf("%s R2 R8 bin%0d im", tag, k), longint'(rd_im_o), m_im[k]);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 done in reset", longint'(done_o), 0);
    chk("R1 overrun in reset", longint'(overrun_o), 0);
    rst_ni = 1'b1;
    model_clear();
    @(posedge clk); #1;
    chk("R1 done after reset", longint'(done_o), 0);
    chk("R1 overrun after reset", longint'(overrun_o), 0);
    for (int k = 0; k < K; k++) begin
      rd_bin_i = KW'(k);
      #0.5;
      chk($sformatf("R1 bin%0d re", k), longint'(rd_re_o), 0);
      chk($sformatf("R1 bin%0d im", k), longint'(rd_im_o), 0);
    end
  endtask

  task automatic t_impulse();
    send_sample(100);
    model_push(100);
    wait_done("impulse R4");
    check_bins("impulse");
    send_sample(-128);
    model_push(-128);
    wait_done("negfull");
    check_bins("negfull");
    send_sample(127);
    model_push(127);
    wait_done("posfull");
    check_bins("posfull");
  endtask

  // longer than the window so the comb term uses old samples (R3)
  task automatic t_stream();
    for (int i = 0; i < 2 * N + 3; i++) begin
      int v;
      v = ((i * 37 + 11) % 256) - 128;
      send_sample(v);
      model_push(v);
      wait_done($sformatf("stream%0d R3", i));
      check_bins($sformatf("stream%0d R3", i));
    end
    chk("R7 no overrun in paced stream", longint'(overrun_o), 0);
  endtask

  task automatic t_overrun();
    send_sample(40);
    repeat (2) @(posedge clk);
    send_sample(-77);
    repeat (2) @(posedge clk);
    send_sample(99);
    model_push(40);
    model_push(-77);
    wait_done("ovr first R6");
    wait_done("ovr held R6");
    chk("R7 overrun set", longint'(overrun_o), 1);
    check_bins("ovr R6 R7 dropped");
    send_sample(5);
    model_push(5);
    wait_done("ovr after");
    chk("R7 overrun sticky", longint'(overrun_o), 1);
    check_bins("ovr after R7");
  endtask

  task automatic t_reset_mid();
    send_sample(60);
    repeat (5) @(posedge clk);
    do_reset();
    chk("R9 overrun cleared", longint'(overrun_o), 0);
    send_sample(50);
    model_push(50);
    wait_done("mid R9");
    check_bins("mid R9");
    send_sample(-20);
    model_push(-20);
    wait_done("mid2 R9");
    check_bins("mid2 R9");
  endtask

  initial begin
    for (int k = 0; k < K; k++) begin
      tc[k] = qround($cos(2.0 * 3.14159265358979323846 * real'(k) / real'(N)));
      ts[k] = qround($sin(2.0 * 3.14159265358979323846 * real'(k) / real'(N)));
    end
    model_clear();
    t_reset();
    t_impulse();
    t_stream();
    t_overrun();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule